// File: doc/BRIEF.md
# Paged-register I2C slave

This block is a byte-wide control register space reached over a two-wire I2C bus. The slave answers one configured 7-bit device address. A write transaction carries a register address byte and one data byte. A read transaction first loads the register pointer with a write transaction. It then issues a repeated START, or a STOP followed by a new START, sends the device address with R/W=1 and receives one byte. SCL and SDA are oversampled by the system clock. The slave pulls SDA low through a single drive-enable output, and the pad is outside the block.

Register addresses 0 to 127 form a flat space. Its writable bytes drive the parallel output `ctrl_regs_o`. Addresses 128 to 255 open a window into one of four banks of 128 bytes, which drive `bank_regs_o`. The bank is chosen by one-hot bits in register 0. A few low addresses have special meaning:
- Address 6 is a live status byte.
- Address 7 reads a counter value from outside the block, and a write to it emits a clear pulse.
- Address 8 mixes stored override bits with live monitor bits.

The block has no streaming interface. The slave never stretches SCL, so it applies no back-pressure to the master. The master owns all bus timing and must keep each SCL phase longer than the synchroniser latency plus one clock. The clear output is a plain single-cycle pulse with no acknowledge.

Top module: `i2cp_slave`

## Requirements
- R1: After reset every stored byte of `ctrl_regs_o` and `bank_regs_o` is 0x00, `sda_oe_o` is low and `blk_clr_o` is low.
- R2: A write (START, device address with R/W=0, register byte, data byte, STOP) to the configured address has all three bytes acknowledged. For a plain writable low address n, the data then appears on `ctrl_regs_o[8n+7:8n]`.
- R3: After the register pointer is loaded by a write, a read works with either a repeated START or a STOP then START. The read is acknowledged and returns the addressed byte MSB first. The slave changes SDA only while SCL is low.
- R4: A device address that differs from `dev_addr_i` is not acknowledged and changes no register. SDA is released whenever the bus is idle.
- R5: Address 6 reads as {`buf_empty_i` in bit 7, `buf_full_i` in bit 6, `board_addr_i` in bits 5:0}. Writes to it are ignored.
- R6: A write of any value to address 7 stores nothing and raises `blk_clr_o` for exactly one clock. A read of address 7 returns `blocked_cnt_i`.
- R7: At address 8, bits 7:4 are writable and appear on `ctrl_regs_o` byte 8, whose bits 3:0 stay 0. A read of address 8 returns the stored bits 7:4 with `ovr_mon_i` in bits 3:0.
- R8: For addresses 128 to 255, when exactly one of register 0 bits 3:0 is set, bit k selects bank k. The byte at address a is entry a-128 of that bank, shown on `bank_regs_o` byte k*128+(a-128).
- R9: When none, or more than one, of register 0 bits 3:0 is set, a write to 128 to 255 is dropped and a read there returns 0x00.
- R10: Addresses 0 to 127 ignore the page bits. Register 0 bits 7:4 are stored as plain control bits.
- R11: Low addresses from `LOW_REGS` (96) to 127 drop writes and read 0x00. Bytes 6 and 7 of `ctrl_regs_o` read 0x00.
- R12: In a write, any byte after the data byte is not acknowledged and not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low |
| dev_addr_i | input | 7 | Configured device address |
| buf_empty_i | input | 1 | Status: buffer empty flag |
| buf_full_i | input | 1 | Status: buffer full flag |
| board_addr_i | input | 6 | Status: board address |
| blocked_cnt_i | input | 8 | Blocked-packet count to read at address 7 |
| ovr_mon_i | input | 4 | Live monitor bits for address 8 |
| blk_clr_o | output | 1 | One-cycle clear pulse for the blocked-packet counter |
| ctrl_regs_o | output | LOW_REGS*8 | Flat image of low registers, byte n at bits 8n+7:8n |
| bank_regs_o | output | 4*BANK_ENTRIES*8 | Flat image of banks, byte k*BANK_ENTRIES+e |

## Verification
The hardest situation to reach is a paged access while register 0 holds an invalid page code, either no bit or two bits set. Reaching it takes a full prior write to register 0, and the result can only be seen through the bank image and a later read. The stimulus first writes a paged byte under a valid page. It then switches register 0 to zero and to two set bits, repeats writes and reads at the same paged address, and restores the valid page to prove the bank byte survived. A per-clock comparison of both register images against a behavioural model catches any stray write in between.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;
  localparam int PAGES = 4;
  localparam logic [7:0] REG_PAGE   = 8'd0;
  localparam logic [7:0] REG_STATUS = 8'd6;
  localparam logic [7:0] REG_CLR    = 8'd7;
  localparam logic [7:0] REG_OVR    = 8'd8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_TX,
    ST_SKIP
  } link_st_e;
endpackage

// File: rtl/i2cp_sync.sv
module i2cp_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '1;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cp_link.sv
module i2cp_link
  import i2cp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic [6:0] dev_addr,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic [7:0] ptr,
  output logic       wr_en,
  output logic [7:0] wr_data
);
  link_st_e   st;
  logic       scl_p, sda_p;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic       rw;
  logic       scl_rise, scl_fall, bus_start, bus_stop;

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
  assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; scl_p <= 1'b1; sda_p <= 1'b1; cnt <= '0;
      sh <= '0; tx <= '0; rw <= 1'b0; sda_oe <= 1'b0;
      ptr <= '0; wr_en <= 1'b0; wr_data <= '0;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
      wr_en <= 1'b0;
      if (bus_start) begin
        st <= ST_DEV; cnt <= '0; sda_oe <= 1'b0;
      end else if (bus_stop) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_DEV, ST_REG, ST_DATA: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == ST_DEV) begin
                if (sh[7:1] == dev_addr) begin
                  sda_oe <= 1'b1;
                  rw     <= sh[0];
                  tx     <= rd_data;
                  st     <= ST_DEV_ACK;
                end else begin
                  st <= ST_SKIP;
                end
              end else if (st == ST_REG) begin
                ptr <= sh; sda_oe <= 1'b1; st <= ST_REG_ACK;
              end else begin
                wr_en <= 1'b1; wr_data <= sh; sda_oe <= 1'b1; st <= ST_DATA_ACK;
              end
            end
          end
          ST_DEV_ACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin st <= ST_TX; sda_oe <= ~tx[7]; end
            else begin st <= ST_REG; sda_oe <= 1'b0; end
          end
          ST_REG_ACK: if (scl_fall) begin
            cnt <= '0; sda_oe <= 1'b0; st <= ST_DATA;
          end
          ST_DATA_ACK: if (scl_fall) begin
            sda_oe <= 1'b0; st <= ST_SKIP;
          end
          ST_TX: if (scl_fall) begin
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0; st <= ST_SKIP;
            end else begin
              tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6];
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: the slave only moves SDA while SCL is low
  p_sda_hold_scl_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_p) |=> $stable(sda_oe));
  // R4: nothing is driven while the bus is idle
  p_idle_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);
  // R2: one data byte produces one write strobe
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

// File: rtl/i2cp_regfile.sv
module i2cp_regfile
  import i2cp_pkg::*;
#(
  parameter int LOW_REGS     = 96,
  parameter int BANK_ENTRIES = 128
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [7:0]                      addr,
  input  logic                            wr_en,
  input  logic [7:0]                      wr_data,
  input  logic                            buf_empty,
  input  logic                            buf_full,
  input  logic [5:0]                      board_addr,
  input  logic [7:0]                      blocked_cnt,
  input  logic [3:0]                      ovr_mon,
  output logic [7:0]                      rd_data,
  output logic                            clr_pulse,
  output logic [LOW_REGS*8-1:0]           ctrl_flat,
  output logic [PAGES*BANK_ENTRIES*8-1:0] bank_flat
);
  localparam int LW = $clog2(LOW_REGS);
  localparam int BW = $clog2(BANK_ENTRIES);
  localparam int PW = $clog2(PAGES);

  logic [7:0]    lo_q   [LOW_REGS];
  logic [7:0]    bank_q [PAGES][BANK_ENTRIES];
  logic [PAGES-1:0] page;
  logic          page_ok, lo_in, lo_wr_ok, bk_in;
  logic [PW-1:0] page_idx;
  logic [2:0]    page_cnt;
  logic [LW-1:0] lo_idx;
  logic [BW-1:0] bk_idx;

  assign page     = lo_q[0][PAGES-1:0];
  assign lo_idx   = addr[LW-1:0];
  assign bk_idx   = addr[BW-1:0];
  assign lo_in    = !addr[7] && (int'(addr) < LOW_REGS);
  assign lo_wr_ok = lo_in && addr != REG_STATUS && addr != REG_CLR;
  assign bk_in    = addr[7] && (int'(addr[6:0]) < BANK_ENTRIES);

  always_comb begin
    page_cnt = '0;
    page_idx = '0;
    for (int p = 0; p < PAGES; p++) begin
      if (page[p]) begin
        page_cnt = page_cnt + 3'd1;
        page_idx = PW'(p);
      end
    end
    page_ok = (page_cnt == 3'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LOW_REGS; i++) lo_q[i] <= '0;
      for (int p = 0; p < PAGES; p++)
        for (int e = 0; e < BANK_ENTRIES; e++) bank_q[p][e] <= '0;
      clr_pulse <= 1'b0;
    end else begin
      clr_pulse <= wr_en && (addr == REG_CLR);
      if (wr_en) begin
        if (lo_wr_ok)
          lo_q[lo_idx] <= (addr == REG_OVR) ? {wr_data[7:4], 4'b0000} : wr_data;
        else if (bk_in && page_ok)
          bank_q[page_idx][bk_idx] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (addr == REG_STATUS)   rd_data = {buf_empty, buf_full, board_addr};
    else if (addr == REG_CLR) rd_data = blocked_cnt;
    else if (addr == REG_OVR) rd_data = {lo_q[REG_OVR[LW-1:0]][7:4], ovr_mon};
    else if (lo_in)           rd_data = lo_q[lo_idx];
    else if (bk_in && page_ok) rd_data = bank_q[page_idx][bk_idx];
  end

  for (genvar i = 0; i < LOW_REGS; i++) begin : g_ctrl
    assign ctrl_flat[i*8 +: 8] = lo_q[i];
  end
  for (genvar p = 0; p < PAGES; p++) begin : g_pg
    for (genvar e = 0; e < BANK_ENTRIES; e++) begin : g_ent
      assign bank_flat[(p*BANK_ENTRIES+e)*8 +: 8] = bank_q[p][e];
    end
  end

  // R6: the clear pulse lasts a single cycle
  p_clr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse);
  // R9: paged writes without a valid page leave every bank untouched
  p_drop_badpage_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[7] && !page_ok) |=> $stable(bank_flat));
  // R10: low addresses never reach a bank
  p_low_no_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr[7]) |=> $stable(bank_flat));
endmodule

// File: rtl/i2cp_slave.sv
module i2cp_slave
  import i2cp_pkg::*;
#(
  parameter int LOW_REGS     = 96,
  parameter int BANK_ENTRIES = 128,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            scl_i,
  input  logic                            sda_i,
  output logic                            sda_oe_o,
  input  logic [6:0]                      dev_addr_i,
  input  logic                            buf_empty_i,
  input  logic                            buf_full_i,
  input  logic [5:0]                      board_addr_i,
  input  logic [7:0]                      blocked_cnt_i,
  input  logic [3:0]                      ovr_mon_i,
  output logic                            blk_clr_o,
  output logic [LOW_REGS*8-1:0]           ctrl_regs_o,
  output logic [PAGES*BANK_ENTRIES*8-1:0] bank_regs_o
);
  logic [1:0] line_s;
  logic [7:0] ptr, wr_data, rd_data;
  logic       wr_en;

  i2cp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(line_s)
  );

  i2cp_link u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .dev_addr(dev_addr_i), .rd_data(rd_data), .sda_oe(sda_oe_o),
    .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data)
  );

  i2cp_regfile #(.LOW_REGS(LOW_REGS), .BANK_ENTRIES(BANK_ENTRIES)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .buf_empty(buf_empty_i), .buf_full(buf_full_i), .board_addr(board_addr_i),
    .blocked_cnt(blocked_cnt_i), .ovr_mon(ovr_mon_i), .rd_data(rd_data),
    .clr_pulse(blk_clr_o), .ctrl_flat(ctrl_regs_o), .bank_flat(bank_regs_o)
  );
endmodule

// File: tb/i2cp_slave_tb_top.sv
module i2cp_slave_tb_top;
  localparam int LOW = 96;
  localparam int BE  = 128;
  localparam int Q   = 6;
  localparam logic [6:0] DEV = 7'h2A;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl_m, sda_m, sda_oe, blk_clr;
  logic buf_empty, buf_full;
  logic [5:0] board;
  logic [7:0] blocked;
  logic [3:0] mon;
  logic [LOW*8-1:0]  ctrl_o, exp_ctrl;
  logic [4*BE*8-1:0] bank_o, exp_bank;
  wire sda_line;
  assign sda_line = sda_m & ~sda_oe;

  int vectors = 0, errors = 0, clr_seen = 0, clr_exp = 0;
  bit cmp_en = 0, finished = 0;

  i2cp_slave #(.LOW_REGS(LOW), .BANK_ENTRIES(BE)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .dev_addr_i(DEV), .buf_empty_i(buf_empty), .buf_full_i(buf_full),
    .board_addr_i(board), .blocked_cnt_i(blocked), .ovr_mon_i(mon),
    .blk_clr_o(blk_clr), .ctrl_regs_o(ctrl_o), .bank_regs_o(bank_o)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // behavioural reference model
  task automatic m_write(int a, logic [7:0] d);
    if (a < 128) begin
      if (a == 7) clr_exp++;
      else if (a == 6 || a >= LOW) ;
      else if (a == 8) exp_ctrl[71:64] = {d[7:4], 4'b0000};
      else exp_ctrl[a*8 +: 8] = d;
    end else if ($countones(exp_ctrl[3:0]) == 1) begin
      for (int k = 0; k < 4; k++)
        if (exp_ctrl[k]) exp_bank[(k*BE + a - 128)*8 +: 8] = d;
    end
  endtask

  function automatic logic [7:0] m_read(int a);
    logic [7:0] r = 8'h00;
    if (a == 6) r = {buf_empty, buf_full, board};
    else if (a == 7) r = blocked;
    else if (a == 8) r = {exp_ctrl[71:68], mon};
    else if (a < LOW) r = exp_ctrl[a*8 +: 8];
    else if (a >= 128 && $countones(exp_ctrl[3:0]) == 1) begin
      for (int k = 0; k < 4; k++)
        if (exp_ctrl[k]) r = exp_bank[(k*BE + a - 128)*8 +: 8];
    end
    return r;
  endfunction

  // per-clock comparison of the register images while the bus is quiet
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      vectors++;
      if (ctrl_o !== exp_ctrl || bank_o !== exp_bank || sda_oe !== 1'b0) begin
        errors++;
        for (int i = 0; i < LOW; i++)
          if (ctrl_o[i*8 +: 8] !== exp_ctrl[i*8 +: 8])
            $display("FAIL R2 ctrl byte %0d got=%h exp=%h", i, ctrl_o[i*8 +: 8], exp_ctrl[i*8 +: 8]);
        for (int i = 0; i < 4*BE; i++)
          if (bank_o[i*8 +: 8] !== exp_bank[i*8 +: 8])
            $display("FAIL R8 bank byte %0d got=%h exp=%h", i, bank_o[i*8 +: 8], exp_bank[i*8 +: 8]);
        if (sda_oe !== 1'b0) $display("FAIL R4 idle sda_oe got=%b exp=0", sda_oe);
      end
    end
  end

  always @(posedge clk) if (rst_n && blk_clr) clr_seen++;

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = !sda_line;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic do_write(logic [6:0] dev, int a, logic [7:0] d, string tag);
    bit a1, a2, a3;
    cmp_en = 0;
    bus_start;
    send_byte({dev, 1'b0}, a1);
    send_byte(8'(a), a2);
    send_byte(d, a3);
    bus_stop;
    if (dev == DEV) m_write(a, d);
    chk({tag, " write acks"}, {29'd0, a1, a2, a3}, (dev == DEV) ? 32'h7 : 32'h0);
    tick(4);
    cmp_en = 1;
  endtask

  task automatic do_read(logic [6:0] dev, int a, bit rep, string tag);
    bit a1, a2, a3;
    logic [7:0] d;
    cmp_en = 0;
    d = 8'h00;
    bus_start;
    send_byte({dev, 1'b0}, a1);
    send_byte(8'(a), a2);
    if (!rep) bus_stop;
    bus_start;
    send_byte({dev, 1'b1}, a3);
    if (a3) recv_byte(d);
    bus_stop;
    if (dev == DEV) begin
      chk({tag, " read acks"}, {29'd0, a1, a2, a3}, 32'h7);
      chk({tag, " read data"}, {24'd0, d}, {24'd0, m_read(a)});
    end else begin
      chk({tag, " foreign read acks"}, {29'd0, a1, a2, a3}, 32'h0);
    end
    tick(4);
    cmp_en = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    bit x1, x2, x3, x4;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    buf_empty = 1'b1; buf_full = 1'b0; board = 6'h2D; blocked = 8'h9C; mon = 4'hA;
    exp_ctrl = '0; exp_bank = '0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk("R1 ctrl image zero", {31'd0, |ctrl_o}, 32'd0);
    chk("R1 bank image zero", {31'd0, |bank_o}, 32'd0);
    chk("R1 sda released", {31'd0, sda_oe}, 32'd0);
    chk("R1 no clear pulse", {31'd0, blk_clr}, 32'd0);
    cmp_en = 1;

    do_write(DEV, 3, 8'hA5, "R2 reg3");
    do_read(DEV, 3, 1'b1, "R3 reg3 repeated start");
    do_read(DEV, 3, 1'b0, "R3 reg3 stop-start");
    do_write(DEV, 1, 8'h3C, "R2 reg1");
    do_write(DEV, 95, 8'h77, "R2 reg95");
    do_read(DEV, 95, 1'b1, "R3 reg95");

    do_write(7'h2B, 3, 8'hFF, "R4 foreign write");
    do_read(7'h15, 3, 1'b1, "R4 foreign read");
    do_read(DEV, 3, 1'b1, "R4 reg3 unchanged");

    do_read(DEV, 6, 1'b1, "R5 status");
    do_write(DEV, 6, 8'h00, "R5 write ignored");
    buf_full = 1'b1; buf_empty = 1'b0; board = 6'h12;
    do_read(DEV, 6, 1'b0, "R5 status live");

    do_read(DEV, 7, 1'b1, "R6 blocked count");
    do_write(DEV, 7, 8'hFF, "R6 clear");
    chk("R6 clear pulses", clr_seen, clr_exp);

    do_write(DEV, 8, 8'h5F, "R7 override");
    chk("R7 ctrl byte8", {24'd0, ctrl_o[71:64]}, 32'h50);
    do_read(DEV, 8, 1'b1, "R7 override mix");

    do_write(DEV, 0, 8'h02, "R8 page1");
    do_write(DEV, 8'h85, 8'hC3, "R8 bank1 e5");
    do_read(DEV, 8'h85, 1'b1, "R8 bank1 e5");
    do_write(DEV, 0, 8'h08, "R8 page3");
    do_write(DEV, 8'hFF, 8'h1E, "R8 bank3 e127");
    do_read(DEV, 8'hFF, 1'b0, "R8 bank3 e127");
    do_read(DEV, 8'h85, 1'b1, "R8 bank3 e5 empty");

    do_write(DEV, 0, 8'h00, "R9 no page");
    do_write(DEV, 8'h90, 8'h44, "R9 dropped");
    do_read(DEV, 8'h90, 1'b1, "R9 no page read");
    do_write(DEV, 0, 8'h03, "R9 two pages");
    do_write(DEV, 8'h85, 8'h99, "R9 dropped two");
    do_read(DEV, 8'h85, 1'b1, "R9 two pages read");
    do_write(DEV, 0, 8'h02, "R9 restore page1");
    do_read(DEV, 8'h85, 1'b1, "R9 bank1 kept");

    do_write(DEV, 0, 8'hF4, "R10 page2 upper bits");
    do_write(DEV, 5, 8'h66, "R10 low under page");
    do_read(DEV, 5, 1'b1, "R10 low read");
    do_read(DEV, 0, 1'b0, "R10 reg0 read");
    do_read(DEV, 8'h85, 1'b1, "R10 bank2 e5 empty");

    do_write(DEV, 100, 8'hAB, "R11 unimplemented");
    do_read(DEV, 100, 1'b1, "R11 unimplemented read");
    do_read(DEV, 127, 1'b0, "R11 top low read");
    chk("R11 ctrl bytes 6 7", {16'd0, ctrl_o[63:48]}, 32'd0);

    cmp_en = 0;
    bus_start;
    send_byte({DEV, 1'b0}, x1);
    send_byte(8'd3, x2);
    send_byte(8'h11, x3);
    send_byte(8'h22, x4);
    bus_stop;
    m_write(3, 8'h11);
    chk("R12 extra byte nacked", {28'd0, x1, x2, x3, x4}, 32'hE);
    tick(4);
    cmp_en = 1;
    do_read(DEV, 3, 1'b1, "R12 only first data stored");
    chk("R6 clear pulses final", clr_seen, clr_exp);

    tick(20);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule